// File: doc/BRIEF.md
# Serial Link Bring-Up Sequencer

This block is the control state machine for one full-duplex serial link port. A supervising controller requests a start, or later a resynchronization. The sequencer then walks the port through a fixed bring-up order. It cycles the port enable off and on, keeps the transmitter quiet while it checks that a signal is present, and selects sync-packet transmission. Only after that does it turn the transmitter on and pulse the receiver's sync-hunt strobe. It then waits a programmable time-out, samples the receiver's sync status, clears CRC errors left over from synchronization, and raises a ready report.

The port keeps sending sync packets while ready is reported. It leaves that mode only when the supervisor grants data mode, which the supervisor does once both ends of the link have reported ready. In data mode the transmitter sends normal traffic (idle or data packets), and the block watches the CRC-error and no-signal inputs. An error raises a link-error output, which also serves as a resynchronization request to the supervisor. The block itself never restarts on its own. A failed signal check or a failed sync sets a sticky fail flag and returns the port to idle.

Top module: `link_bringup_seq`

## Requirements
- R1: A start_req pulse, accepted in any state, drives port_en low in the following cycle and high again one cycle later, before any other step. It also clears sync_fail and link_err in that same following cycle.
- R2: tx_en stays low during the port-enable and signal-check steps, and tx_en is never high while port_en is low.
- R3: If no_signal is high in the signal-check cycle (the third cycle after start_req), sync_fail is set and the port returns to idle (all control outputs low). No hunt pulse is issued.
- R4: tx_sync_sel is high for one full cycle before tx_en rises, and it stays high until data mode is granted.
- R5: hunt_pulse is a single-cycle pulse, issued in the cycle after tx_en rises, while port_en and tx_en are high. It occurs exactly once per bring-up.
- R6: sync_status is sampled sync_tmo+1 cycles after the hunt cycle. A value of 0 at that point sets sync_fail and returns the port to idle, with no retry.
- R7: After a successful sync, crc_clr pulses for one cycle. ready_rpt then stays high, with sync packets still selected, until data_grant arrives.
- R8: data_grant while ready_rpt is high moves the port to data mode in the next cycle: data_mode goes high, and tx_sync_sel and ready_rpt go low.
- R9: In data mode, crc_error or no_signal sets link_err in the next cycle and drops data_mode. link_err stays set, and the port stays enabled and transmitting, until the next start_req.
- R10: data_grant has no effect outside the ready step: when data_grant is held high before sync completes, data_mode stays low.
- R11: While reset is asserted, every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_req | input | 1 | Start or resynchronization request pulse from the supervisor |
| sync_tmo | input | TMO_W | Sync time-out length in cycles |
| no_signal | input | 1 | Receiver reports no incoming signal |
| sync_status | input | 1 | Receiver reports synchronization achieved |
| crc_error | input | 1 | Receiver reports a CRC error |
| data_grant | input | 1 | Supervisor allows leaving sync-packet mode |
| port_en | output | 1 | Port enable |
| tx_en | output | 1 | Serial transmission enable |
| tx_sync_sel | output | 1 | 1 selects sync packets, 0 selects normal traffic |
| hunt_pulse | output | 1 | One-cycle strobe that starts receiver synchronization |
| crc_clr | output | 1 | One-cycle strobe that clears latched CRC errors |
| ready_rpt | output | 1 | Ready report to the supervisor |
| data_mode | output | 1 | Link is in data mode |
| sync_fail | output | 1 | Sticky: the last bring-up failed |
| link_err | output | 1 | Sticky data-mode error, also a resynchronization request |

## Verification
Every control output is a registered-state decode, so a start_req sampled at a clock edge is visible one cycle later. The signal check falls in the third cycle after start_req. The hunt pulse comes in the sixth, and sync_status is due sync_tmo+1 cycles after the hunt cycle. data_mode and link_err follow their causes by exactly one cycle. The bench advances a behavioural reference model at each rising edge from the same inputs the design sees, and it compares all outputs at the following falling edge. Every result is therefore checked in exactly the cycle it is due, and scenario checks are placed at cycle counts derived from these latencies.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PORT_OFF,
    ST_PORT_ON,
    ST_SIG_CHECK,
    ST_SYNC_SEL,
    ST_TX_ON,
    ST_HUNT,
    ST_TMO_WAIT,
    ST_CRC_CLEAR,
    ST_READY,
    ST_DATA,
    ST_LINK_ERR
  } lbs_state_e;

  typedef struct packed {
    logic port_en;
    logic tx_en;
    logic tx_sync_sel;
    logic hunt_pulse;
    logic crc_clr;
    logic ready_rpt;
    logic data_mode;
  } lbs_ctl_t;

endpackage

// File: rtl/lbs_rst_sync.sv
module lbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/lbs_timer.sv
module lbs_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R6: the time-out counter never wraps below zero
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !zero);
endmodule

// File: rtl/lbs_flags.sv
module lbs_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic fail_evt,
  input  logic err_evt,
  output logic sync_fail,
  output logic link_err
);
  logic sf_q, sf_en, sf_d;
  logic le_q, le_en, le_d;

  always_comb begin
    sf_en = start_req | fail_evt;
    sf_d  = !start_req;
    le_en = start_req | err_evt;
    le_d  = !start_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_q <= 1'b0;
      le_q <= 1'b0;
    end else begin
      if (sf_en) sf_q <= sf_d;
      if (le_en) le_q <= le_d;
    end
  end

  assign sync_fail = sf_q;
  assign link_err  = le_q;

  // R1: a start request clears both sticky flags
  a_r1_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> (!sync_fail && !link_err));
  // R9: link error stays until the next start request
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (link_err && !start_req) |=> link_err);
endmodule

// File: rtl/lbs_ctrl.sv
module lbs_ctrl
  import lbs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_req,
  input  logic     no_signal,
  input  logic     sync_status,
  input  logic     crc_error,
  input  logic     data_grant,
  input  logic     tmr_zero,
  output logic     tmr_load,
  output logic     tmr_dec,
  output logic     fail_evt,
  output logic     err_evt,
  output lbs_ctl_t ctl
);
  lbs_state_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    fail_evt = 1'b0;
    err_evt  = 1'b0;
    if (start_req) begin
      st_d = ST_PORT_OFF;
    end else begin
      unique case (st_q)
        ST_IDLE:      st_d = ST_IDLE;
        ST_PORT_OFF:  st_d = ST_PORT_ON;
        ST_PORT_ON:   st_d = ST_SIG_CHECK;
        ST_SIG_CHECK: begin
          if (no_signal) begin
            fail_evt = 1'b1;
            st_d     = ST_IDLE;
          end else begin
            st_d = ST_SYNC_SEL;
          end
        end
        ST_SYNC_SEL:  st_d = ST_TX_ON;
        ST_TX_ON:     st_d = ST_HUNT;
        ST_HUNT: begin
          tmr_load = 1'b1;
          st_d     = ST_TMO_WAIT;
        end
        ST_TMO_WAIT: begin
          if (!tmr_zero) begin
            tmr_dec = 1'b1;
          end else if (sync_status) begin
            st_d = ST_CRC_CLEAR;
          end else begin
            fail_evt = 1'b1;
            st_d     = ST_IDLE;
          end
        end
        ST_CRC_CLEAR: st_d = ST_READY;
        ST_READY:     if (data_grant) st_d = ST_DATA;
        ST_DATA: begin
          if (crc_error || no_signal) begin
            err_evt = 1'b1;
            st_d    = ST_LINK_ERR;
          end
        end
        ST_LINK_ERR:  st_d = ST_LINK_ERR;
        default:      st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    ctl             = '0;
    ctl.port_en     = (st_q != ST_IDLE) && (st_q != ST_PORT_OFF);
    ctl.tx_en       = (st_q == ST_TX_ON) || (st_q == ST_HUNT) ||
                      (st_q == ST_TMO_WAIT) || (st_q == ST_CRC_CLEAR) ||
                      (st_q == ST_READY) || (st_q == ST_DATA) ||
                      (st_q == ST_LINK_ERR);
    ctl.tx_sync_sel = (st_q == ST_SYNC_SEL) || (st_q == ST_TX_ON) ||
                      (st_q == ST_HUNT) || (st_q == ST_TMO_WAIT) ||
                      (st_q == ST_CRC_CLEAR) || (st_q == ST_READY);
    ctl.hunt_pulse  = (st_q == ST_HUNT);
    ctl.crc_clr     = (st_q == ST_CRC_CLEAR);
    ctl.ready_rpt   = (st_q == ST_READY);
    ctl.data_mode   = (st_q == ST_DATA);
  end

  // R1: port enable drops in the cycle after a start request
  a_r1_port_drop: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !ctl.port_en);
  // R2: no transmission without port enable
  a_r2_tx_needs_port: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.tx_en |-> ctl.port_en);
  // R3: a missing signal at the check never reaches the transmitter
  a_r3_nosig_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SIG_CHECK && no_signal && !start_req) |=> (!ctl.tx_en && !ctl.hunt_pulse));
  // R4: sync packets selected a cycle before the transmitter starts
  a_r4_sel_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.tx_en) |-> (ctl.tx_sync_sel && $past(ctl.tx_sync_sel)));
  // R5: hunt is one cycle wide and follows a running transmitter
  a_r5_hunt_single: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.hunt_pulse |=> !ctl.hunt_pulse);
  a_r5_hunt_tx: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.hunt_pulse |-> (ctl.tx_en && $past(ctl.tx_en)));
  // R7: CRC clear is followed by the ready report
  a_r7_clr_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.crc_clr && !start_req) |=> ctl.ready_rpt);
  // R8: data mode only after ready and a grant
  a_r8_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.data_mode) |-> ($past(ctl.ready_rpt) && $past(data_grant)));
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq #(
  parameter int TMO_W      = 16,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [TMO_W-1:0] sync_tmo,
  input  logic             no_signal,
  input  logic             sync_status,
  input  logic             crc_error,
  input  logic             data_grant,
  output logic             port_en,
  output logic             tx_en,
  output logic             tx_sync_sel,
  output logic             hunt_pulse,
  output logic             crc_clr,
  output logic             ready_rpt,
  output logic             data_mode,
  output logic             sync_fail,
  output logic             link_err
);
  import lbs_pkg::*;

  logic     rst_sync_n;
  logic     tmr_load, tmr_dec, tmr_zero;
  logic     fail_evt, err_evt;
  lbs_ctl_t ctl;

  lbs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lbs_timer #(.W(TMO_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .dec      (tmr_dec),
    .load_val (sync_tmo),
    .zero     (tmr_zero)
  );

  lbs_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_req   (start_req),
    .no_signal   (no_signal),
    .sync_status (sync_status),
    .crc_error   (crc_error),
    .data_grant  (data_grant),
    .tmr_zero    (tmr_zero),
    .tmr_load    (tmr_load),
    .tmr_dec     (tmr_dec),
    .fail_evt    (fail_evt),
    .err_evt     (err_evt),
    .ctl         (ctl)
  );

  lbs_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_req (start_req),
    .fail_evt  (fail_evt),
    .err_evt   (err_evt),
    .sync_fail (sync_fail),
    .link_err  (link_err)
  );

  assign port_en     = ctl.port_en;
  assign tx_en       = ctl.tx_en;
  assign tx_sync_sel = ctl.tx_sync_sel;
  assign hunt_pulse  = ctl.hunt_pulse;
  assign crc_clr     = ctl.crc_clr;
  assign ready_rpt   = ctl.ready_rpt;
  assign data_mode   = ctl.data_mode;

  // R11: outputs quiet while the synchronized reset is held
  always_comb begin
    if (!rst_sync_n) begin
      a_r11_reset_quiet: assert (!port_en && !tx_en && !hunt_pulse && !sync_fail && !link_err);
    end
  end
endmodule

// File: tb/link_bringup_seq_tb.sv
module link_bringup_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;

  localparam int P_IDLE = 0, P_OFF = 1, P_ON = 2, P_CHK = 3, P_SEL = 4, P_TXON = 5,
                 P_HUNT = 6, P_WAIT = 7, P_CLR = 8, P_RDY = 9, P_DATA = 10, P_ERR = 11;

  logic clk = 1'b0;
  logic rst_n;
  logic start_req, no_signal, sync_status, crc_error, data_grant;
  logic [TW-1:0] sync_tmo;
  logic port_en, tx_en, tx_sync_sel, hunt_pulse, crc_clr, ready_rpt, data_mode;
  logic sync_fail, link_err;

  int checks = 0;
  int errors = 0;
  int m_ph;
  int m_cnt;
  bit m_fail, m_lerr;
  int hunts;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_bringup_seq #(.TMO_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .sync_tmo(sync_tmo),
    .no_signal(no_signal), .sync_status(sync_status), .crc_error(crc_error),
    .data_grant(data_grant), .port_en(port_en), .tx_en(tx_en),
    .tx_sync_sel(tx_sync_sel), .hunt_pulse(hunt_pulse), .crc_clr(crc_clr),
    .ready_rpt(ready_rpt), .data_mode(data_mode), .sync_fail(sync_fail),
    .link_err(link_err)
  );

  // behavioural reference: phase number advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = P_IDLE; m_cnt = 0; m_fail = 0; m_lerr = 0;
    end else if (start_req) begin
      m_ph = P_OFF; m_fail = 0; m_lerr = 0;
    end else begin
      if (m_ph == P_CHK && no_signal) begin m_fail = 1; m_ph = P_IDLE; end
      else if (m_ph == P_HUNT) begin m_cnt = int'(sync_tmo); m_ph = P_WAIT; end
      else if (m_ph == P_WAIT) begin
        if (m_cnt > 0) m_cnt--;
        else if (sync_status) m_ph = P_CLR;
        else begin m_fail = 1; m_ph = P_IDLE; end
      end
      else if (m_ph == P_RDY) begin if (data_grant) m_ph = P_DATA; end
      else if (m_ph == P_DATA) begin
        if (crc_error || no_signal) begin m_lerr = 1; m_ph = P_ERR; end
      end
      else if (m_ph != P_IDLE && m_ph != P_ERR) m_ph++;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk("R1 port_en",     port_en,     m_ph >= P_ON);
    chk("R2 tx_en",       tx_en,       m_ph >= P_TXON);
    chk("R4 tx_sync_sel", tx_sync_sel, m_ph >= P_SEL && m_ph <= P_RDY);
    chk("R5 hunt_pulse",  hunt_pulse,  m_ph == P_HUNT);
    chk("R7 crc_clr",     crc_clr,     m_ph == P_CLR);
    chk("R7 ready_rpt",   ready_rpt,   m_ph == P_RDY);
    chk("R8 data_mode",   data_mode,   m_ph == P_DATA);
    chk("R6 sync_fail",   sync_fail,   m_fail);
    chk("R9 link_err",    link_err,    m_lerr);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hunt_pulse) hunts++;
      compare();
    end
  endtask

  task automatic kick();
    start_req = 1'b1;
    cyc(1);
    start_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_req = 0; no_signal = 0; sync_status = 0;
    crc_error = 0; data_grant = 0; sync_tmo = 3;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset port_en", port_en, 1'b0);
    chk("R11 reset tx_en", tx_en, 1'b0);
    chk("R11 reset flags", sync_fail | link_err | hunt_pulse, 1'b0);
    rst_n = 1'b1;
    cyc(4);

    // R3: no signal at the check
    no_signal = 1; hunts = 0;
    kick();
    cyc(8);
    chk("R3 fail set", sync_fail, 1'b1);
    chk("R3 no hunt", hunts != 0, 1'b0);
    chk("R3 idle", port_en | tx_en, 1'b0);
    no_signal = 0;

    // R6: sync never reached, timeout 5
    sync_tmo = 5; sync_status = 0;
    kick();
    chk("R1 fail cleared", sync_fail, 1'b0);
    chk("R1 port off", port_en, 1'b0);
    cyc(1);
    chk("R1 port back on", port_en, 1'b1);
    cyc(20);
    chk("R6 fail after timeout", sync_fail, 1'b1);
    chk("R6 idle", port_en, 1'b0);

    // R10 then R8: grant held from start, timeout 3
    sync_tmo = 3; sync_status = 1; data_grant = 1; hunts = 0;
    kick();
    cyc(9);
    chk("R10 grant ignored", data_mode, 1'b0);
    cyc(4);
    chk("R8 data mode", data_mode, 1'b1);
    chk("R8 normal traffic", tx_sync_sel, 1'b0);
    chk("R5 one hunt", hunts == 1, 1'b1);
    data_grant = 0;
    cyc(3);

    // R9: crc error in data mode
    crc_error = 1;
    cyc(1);
    crc_error = 0;
    cyc(5);
    chk("R9 link_err held", link_err, 1'b1);
    chk("R9 no self restart", port_en & tx_en & !data_mode, 1'b1);
    kick();
    chk("R1 link_err cleared", link_err, 1'b0);

    // R7 with timeout 0, delayed grant, then no_signal error
    sync_tmo = 0;
    cyc(12);
    chk("R7 ready waiting", ready_rpt & tx_sync_sel, 1'b1);
    data_grant = 1;
    cyc(1);
    data_grant = 0;
    cyc(2);
    no_signal = 1;
    cyc(2);
    no_signal = 0;
    chk("R9 no_signal error", link_err, 1'b1);
    cyc(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule